// File: doc/BRIEF.md
# Quad Depth Test Unit

This block runs the depth comparison for one 2x2 quad of fragments against the packed depth/stencil words that the frame buffer holds for those four pixels. Each frame-buffer word keeps a 24-bit depth in its low bits and an 8-bit stencil value in its top byte. Each fragment depth arrives as an unsigned fixed-point fraction in which the value 2^16 means 1.0. The block scales it to the 24-bit depth range, compares it with the stored depth under one of eight selectable functions, and narrows the incoming live-pixel mask.

For each quad the block reports two masks. The raw compare mask is the comparison result before polarity is applied. The updated live mask is the incoming mask ANDed with the pass decision. The block also returns the four words to write back and the byte offset of the quad inside a 32x32 tile of 4-byte pixels. The offset is computed from the quad's pixel coordinates within the tile. The block is one registered pipeline stage and accepts a new quad on every cycle.

Top module: `quad_depth_test`

## Requirements
- R1: In every word, bits 23:0 are the stored depth and bits 31:24 are the stencil. Each output word carries the stencil byte of its input word unchanged.
- R2: A fragment depth `f` (17 bits, 0x10000 = 1.0) converts to `floor(min(f,0x10000) * 0xFFFFFF / 0x10000)`. Any input of 1.0 or more converts to 0xFFFFFF, and 0 converts to 0.
- R3: `zfunc` encodes 0 NEVER, 1 LESS, 2 EQUAL, 3 LEQUAL, 4 GREATER, 5 NOTEQUAL, 6 GEQUAL, 7 ALWAYS. The raw compare bit of a lane is (frag == stored) for EQUAL and NOTEQUAL, (frag > stored) for GREATER and LEQUAL, and (stored > frag) for LESS and GEQUAL.
- R4: The updated live bit of a lane is the input live bit AND the pass decision. The pass decision equals the raw compare bit for LESS, EQUAL and GREATER, and its complement for LEQUAL, NOTEQUAL and GEQUAL. A live bit is never raised.
- R5: NEVER drives both the live mask and the compare mask to 0000.
- R6: ALWAYS passes the live mask through unchanged and sets the compare mask to 1111.
- R7: With depth write enabled, a lane whose updated live bit is 1 has bits 23:0 replaced by the converted fragment depth. Every other lane keeps its stored depth.
- R8: With depth write disabled, every output word equals its input word bit for bit, whatever the compare result.
- R9: Lane order is bit i of each mask and bits [32i+31:32i] of each word, for the four pixels of the quad. The quad offset is `((y>>1)*16 + (x>>1))*16` for tile coordinates x, y in 0..31, so it is always a multiple of 16.
- R10: Results appear one clock after a cycle with `in_valid` high, with `out_valid` high in that cycle. A cycle without `in_valid` gives `out_valid` low in the next cycle and leaves the result outputs unchanged. Back-to-back quads are accepted.
- R11: During reset `out_valid`, `live_out` and `cmp_out` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Quad present on the inputs this cycle |
| frag_depth | input | 68 | Four 17-bit fragment depths, lane i at [17i+16:17i] |
| fb_word | input | 128 | Four stored stencil/depth words |
| live_in | input | 4 | Incoming live-pixel mask |
| zfunc | input | 3 | Compare function select |
| zwrite_en | input | 1 | Depth write enable |
| quad_x | input | 5 | Pixel x within the tile |
| quad_y | input | 5 | Pixel y within the tile |
| out_valid | output | 1 | Result registers hold a new quad |
| live_out | output | 4 | Updated live mask |
| cmp_out | output | 4 | Raw per-lane compare mask |
| word_out | output | 128 | Merged stencil/depth words to write back |
| quad_offset | output | 12 | Byte offset of the quad within the tile |

## Verification
The bench sweeps every compare function against every live mask, with writes on and off. It uses lane patterns that place each fragment one step below, equal to, or one step above its stored depth, so a swapped operand order or an inverted polarity shows up as a wrong mask on the lanes at the boundary. The patterns include fragment depths of 0, exactly 1.0 and above 1.0. An off-by-one in the scale factor or a missing clamp changes the written depth on those lanes. Write-back is checked on lanes that were live but failed, where a design that takes its write select from the compare mask instead of the live mask would store the wrong depth. Stencil bytes that differ per lane expose any masking that spills into the top byte. A sweep of all 32x32 coordinates catches a wrong halving or row stride in the offset.

// File: rtl/qdt_pkg.sv
package qdt_pkg;

  typedef enum logic [2:0] {
    ZF_NEVER    = 3'd0,
    ZF_LESS     = 3'd1,
    ZF_EQUAL    = 3'd2,
    ZF_LEQUAL   = 3'd3,
    ZF_GREATER  = 3'd4,
    ZF_NOTEQUAL = 3'd5,
    ZF_GEQUAL   = 3'd6,
    ZF_ALWAYS   = 3'd7
  } zfunc_e;

  typedef struct packed {
    logic cmp;   // raw comparison result reported to the caller
    logic pass;  // decision ANDed into the live mask
  } zres_t;

  // Pick the raw comparison and its polarity for one lane.
  // eq  : frag == stored, fgt : frag > stored, sgt : stored > frag
  function automatic zres_t zresolve(input zfunc_e fn, input logic eq,
                                     input logic fgt, input logic sgt);
    zres_t r;
    unique case (fn)
      ZF_NEVER:    r = '{cmp: 1'b0, pass: 1'b0};
      ZF_ALWAYS:   r = '{cmp: 1'b1, pass: 1'b1};
      ZF_EQUAL:    r = '{cmp: eq,   pass: eq};
      ZF_NOTEQUAL: r = '{cmp: eq,   pass: ~eq};
      ZF_GREATER:  r = '{cmp: fgt,  pass: fgt};
      ZF_LEQUAL:   r = '{cmp: fgt,  pass: ~fgt};
      ZF_LESS:     r = '{cmp: sgt,  pass: sgt};
      ZF_GEQUAL:   r = '{cmp: sgt,  pass: ~sgt};
      default:     r = '{cmp: 1'b0, pass: 1'b0};
    endcase
    return r;
  endfunction

endpackage

// File: rtl/qdt_zconv.sv
module qdt_zconv #(
  parameter int FRAC_BITS = 16,
  parameter int DEPTH_W   = 24
) (
  input  logic [FRAC_BITS:0]   frac_i,
  output logic [DEPTH_W-1:0]   z_o
);
  localparam int PW = FRAC_BITS + 1 + DEPTH_W;
  localparam logic [FRAC_BITS:0] UNIT = {1'b1, {FRAC_BITS{1'b0}}};
  localparam logic [DEPTH_W-1:0] ZMAX = '1;

  // Clamp to 1.0, scale by the full depth range, drop the fraction.
  function automatic logic [DEPTH_W-1:0] scale_depth(input logic [FRAC_BITS:0] f);
    logic [FRAC_BITS:0] c;
    logic [PW-1:0]      prod;
    c    = (f > UNIT) ? UNIT : f;
    prod = PW'(c) * PW'(ZMAX);
    return DEPTH_W'(prod >> FRAC_BITS);
  endfunction

  logic clamp_hit;
  logic zero_in;
  assign clamp_hit = (frac_i >= UNIT);
  assign zero_in   = (frac_i == '0);
  assign z_o       = scale_depth(frac_i);

  always_comb begin
    // R2
    clamp_top_chk: assert (!clamp_hit || z_o == ZMAX);
    // R2
    zero_floor_chk: assert (!zero_in || z_o == '0);
  end

endmodule

// File: rtl/qdt_lane.sv
module qdt_lane
  import qdt_pkg::*;
#(
  parameter int FRAC_BITS = 16,
  parameter int DEPTH_W   = 24,
  parameter int WORD_W    = 32
) (
  input  logic [FRAC_BITS:0]  frag_i,
  input  logic [WORD_W-1:0]   fb_i,
  input  zfunc_e              fn_i,
  input  logic                live_i,
  input  logic                wr_i,
  output logic                cmp_o,
  output logic                live_o,
  output logic [WORD_W-1:0]   word_o
);
  localparam int STEN_W = WORD_W - DEPTH_W;

  logic [DEPTH_W-1:0] frag_z;
  logic [DEPTH_W-1:0] store_z;
  logic [STEN_W-1:0]  sten;
  logic               z_eq, frag_gt, store_gt;
  zres_t              res;
  logic               z_take;
  logic [DEPTH_W-1:0] next_z;

  qdt_zconv #(.FRAC_BITS(FRAC_BITS), .DEPTH_W(DEPTH_W)) u_conv (
    .frac_i (frag_i),
    .z_o    (frag_z)
  );

  assign store_z  = fb_i[DEPTH_W-1:0];
  assign sten     = fb_i[WORD_W-1:DEPTH_W];
  assign z_eq     = (frag_z == store_z);
  assign frag_gt  = (frag_z > store_z);
  assign store_gt = (store_z > frag_z);
  assign res      = zresolve(fn_i, z_eq, frag_gt, store_gt);

  assign cmp_o  = res.cmp;
  assign live_o = live_i & res.pass;
  assign z_take = wr_i & live_o;
  assign next_z = z_take ? frag_z : store_z;
  assign word_o = {sten, next_z};

  always_comb begin
    // R4
    live_never_rises_chk: assert (live_i || !live_o);
    // R8
    untouched_word_chk: assert (z_take || word_o == fb_i);
    // R3
    one_relation_chk: assert ($countones({z_eq, frag_gt, store_gt}) == 1);
  end

endmodule

// File: rtl/qdt_offset.sv
module qdt_offset #(
  parameter int TILE_DIM  = 32,
  parameter int PIX_BYTES = 4,
  parameter int COORD_W   = 5,
  parameter int OFS_W     = 12
) (
  input  logic [COORD_W-1:0] x_i,
  input  logic [COORD_W-1:0] y_i,
  output logic [OFS_W-1:0]   ofs_o
);
  localparam int QROW       = TILE_DIM / 2;
  localparam int QUAD_BYTES = 4 * PIX_BYTES;
  localparam int ALIGN      = $clog2(QUAD_BYTES);

  // Quad index in row-major order of quads, times bytes per quad.
  function automatic logic [OFS_W-1:0] quad_byte_ofs(input logic [COORD_W-1:0] x,
                                                     input logic [COORD_W-1:0] y);
    logic [OFS_W-1:0] qx, qy;
    qx = OFS_W'(x >> 1);
    qy = OFS_W'(y >> 1);
    return OFS_W'((qy * OFS_W'(QROW) + qx) * OFS_W'(QUAD_BYTES));
  endfunction

  assign ofs_o = quad_byte_ofs(x_i, y_i);

  always_comb begin
    // R9
    quad_align_chk: assert (ofs_o[ALIGN-1:0] == '0);
  end

endmodule

// File: rtl/quad_depth_test.sv
module quad_depth_test
  import qdt_pkg::*;
#(
  parameter int  LANES     = 4,
  parameter int  FRAC_BITS = 16,
  parameter int  DEPTH_W   = 24,
  parameter int  WORD_W    = 32,
  parameter int  TILE_DIM  = 32,
  parameter int  PIX_BYTES = 4,
  localparam int FRAC_W    = FRAC_BITS + 1,
  localparam int COORD_W   = $clog2(TILE_DIM),
  localparam int OFS_W     = $clog2(TILE_DIM * TILE_DIM * PIX_BYTES)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_valid,
  input  logic [LANES*FRAC_W-1:0]   frag_depth,
  input  logic [LANES*WORD_W-1:0]   fb_word,
  input  logic [LANES-1:0]          live_in,
  input  logic [2:0]                zfunc,
  input  logic                      zwrite_en,
  input  logic [COORD_W-1:0]        quad_x,
  input  logic [COORD_W-1:0]        quad_y,
  output logic                      out_valid,
  output logic [LANES-1:0]          live_out,
  output logic [LANES-1:0]          cmp_out,
  output logic [LANES*WORD_W-1:0]   word_out,
  output logic [OFS_W-1:0]          quad_offset
);

  zfunc_e                  fn;
  logic [LANES-1:0]        cmp_n;
  logic [LANES-1:0]        live_n;
  logic [LANES*WORD_W-1:0] word_n;
  logic [OFS_W-1:0]        ofs_n;

  assign fn = zfunc_e'(zfunc);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    qdt_lane #(
      .FRAC_BITS (FRAC_BITS),
      .DEPTH_W   (DEPTH_W),
      .WORD_W    (WORD_W)
    ) u_lane (
      .frag_i (frag_depth[l*FRAC_W +: FRAC_W]),
      .fb_i   (fb_word[l*WORD_W +: WORD_W]),
      .fn_i   (fn),
      .live_i (live_in[l]),
      .wr_i   (zwrite_en),
      .cmp_o  (cmp_n[l]),
      .live_o (live_n[l]),
      .word_o (word_n[l*WORD_W +: WORD_W])
    );

    // R1
    stencil_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> word_out[l*WORD_W+DEPTH_W +: WORD_W-DEPTH_W]
                    == $past(fb_word[l*WORD_W+DEPTH_W +: WORD_W-DEPTH_W]));
  end

  qdt_offset #(
    .TILE_DIM  (TILE_DIM),
    .PIX_BYTES (PIX_BYTES),
    .COORD_W   (COORD_W),
    .OFS_W     (OFS_W)
  ) u_ofs (
    .x_i   (quad_x),
    .y_i   (quad_y),
    .ofs_o (ofs_n)
  );

  // Single result register stage, loaded only by a valid quad.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      live_out    <= '0;
      cmp_out     <= '0;
      word_out    <= '0;
      quad_offset <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        live_out    <= live_n;
        cmp_out     <= cmp_n;
        word_out    <= word_n;
        quad_offset <= ofs_n;
      end
    end
  end

  // R10
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  // R10
  valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(live_out) && $stable(word_out) && $stable(cmp_out)));
  // R4
  live_subset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((live_out & ~$past(live_in)) == '0));
  // R5
  never_kill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(zfunc) == 3'(ZF_NEVER)) |-> (live_out == '0 && cmp_out == '0));
  // R6
  always_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(zfunc) == 3'(ZF_ALWAYS)) |->
      (live_out == $past(live_in) && cmp_out == '1));
  // R8
  nowrite_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !$past(zwrite_en)) |-> word_out == $past(fb_word));

endmodule

// File: tb/tb_quad_depth_test.sv
module tb_quad_depth_test;
  localparam int LANES = 4;
  localparam int FW    = 17;
  localparam int WW    = 32;

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic                 in_valid = 1'b0;
  logic [LANES*FW-1:0]  frag_depth = '0;
  logic [LANES*WW-1:0]  fb_word = '0;
  logic [LANES-1:0]     live_in = '0;
  logic [2:0]           zfunc = '0;
  logic                 zwrite_en = 1'b0;
  logic [4:0]           quad_x = '0;
  logic [4:0]           quad_y = '0;
  logic                 out_valid;
  logic [LANES-1:0]     live_out;
  logic [LANES-1:0]     cmp_out;
  logic [LANES*WW-1:0]  word_out;
  logic [11:0]          quad_offset;

  int n_vec  = 0;
  int n_fail = 0;

  bit [3:0]   e_live, e_cmp;
  bit [127:0] e_word;
  bit [11:0]  e_ofs;
  bit         pend = 0;

  always #10 clk = ~clk;

  quad_depth_test dut (
    .clk, .rst_n, .in_valid, .frag_depth, .fb_word, .live_in, .zfunc,
    .zwrite_en, .quad_x, .quad_y, .out_valid, .live_out, .cmp_out,
    .word_out, .quad_offset
  );

  task automatic chk(input string tag, input bit [127:0] act, input bit [127:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic longint zc(input longint f);
    longint c;
    c = (f > 65536) ? 65536 : f;
    return (c * 16777215) >>> 16;
  endfunction

  function automatic longint pick_frag(input int p, input int l);
    longint tbl [8] = '{0, 1, 32768, 65535, 65536, 131071, 12345, 50000};
    return tbl[(p * 3 + l * 5) % 8];
  endfunction

  task automatic check_prev();
    chk("R10 out_valid", 128'(out_valid), 128'(1));
    chk("R4/R5/R6 live_out", 128'(live_out), 128'(e_live));
    chk("R3/R5/R6 cmp_out", 128'(cmp_out), 128'(e_cmp));
    chk("R1/R2/R7/R8 word_out", word_out, e_word);
    chk("R9 quad_offset", 128'(quad_offset), 128'(e_ofs));
  endtask

  // Drive one quad and compute its expected result from the requirements.
  task automatic drive(input int fn, input int lv, input bit wr, input int p, input int idx);
    longint fz, bz, newz, st;
    bit c, ps;
    bit [3:0] lvb;
    lvb = 4'(lv);
    for (int l = 0; l < LANES; l++) begin
      fz = zc(pick_frag(p, l));
      bz = (fz + ((p + l) % 3) - 1) & 64'hFFFFFF;
      st = (p * 37 + l * 11 + 90 + idx) & 255;
      frag_depth[l*FW +: FW] = FW'(pick_frag(p, l));
      fb_word[l*WW +: WW] = WW'((st << 24) | bz);
      case (fn)
        0: begin c = 0;         ps = 0;        end
        1: begin c = (fz < bz); ps = (fz < bz); end
        2: begin c = (fz == bz); ps = (fz == bz); end
        3: begin c = (fz > bz); ps = (fz <= bz); end
        4: begin c = (fz > bz); ps = (fz > bz); end
        5: begin c = (fz == bz); ps = (fz != bz); end
        6: begin c = (fz < bz); ps = (fz >= bz); end
        default: begin c = 1;   ps = 1;        end
      endcase
      e_cmp[l]  = c;
      e_live[l] = lvb[l] & ps;
      newz = (wr && e_live[l]) ? fz : bz;
      e_word[l*WW +: WW] = WW'((st << 24) | newz);
    end
    quad_x = 5'(idx % 32);
    quad_y = 5'((idx / 32) % 32);
    e_ofs = 12'((((idx / 32) % 32) / 2 * 16 + (idx % 32) / 2) * 16);
    live_in = lvb;
    zfunc = 3'(fn);
    zwrite_en = wr;
    in_valid = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL R10 watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

  initial begin
    int idx;
    idx = 0;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 out_valid in reset", 128'(out_valid), 128'(0));
    chk("R11 live_out in reset", 128'(live_out), 128'(0));
    chk("R11 cmp_out in reset", 128'(cmp_out), 128'(0));
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 no output before first quad", 128'(out_valid), 128'(0));

    // Back-to-back sweep: every function, live mask, write mode, pattern.
    for (int fn = 0; fn < 8; fn++)
      for (int lv = 0; lv < 16; lv++)
        for (int wr = 0; wr < 2; wr++)
          for (int p = 0; p < 6; p++) begin
            @(negedge clk);
            if (pend) check_prev();
            drive(fn, lv, bit'(wr), p, idx);
            pend = 1;
            idx++;
          end
    @(negedge clk);
    check_prev();
    in_valid = 1'b0;
    live_in  = 4'h0;
    fb_word  = '1;
    @(negedge clk);
    // R10 an idle cycle drops out_valid and holds the results
    chk("R10 idle out_valid", 128'(out_valid), 128'(0));
    chk("R10 idle hold live_out", 128'(live_out), 128'(e_live));
    chk("R10 idle hold word_out", word_out, e_word);

    // R2 and R7: lanes at 1.0 and beyond write 0xFFFFFF under ALWAYS
    drive(7, 15, 1'b1, 4, 5);
    @(negedge clk);
    check_prev();
    in_valid = 1'b0;
    @(negedge clk);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

endmodule